// File: doc/BRIEF.md
# ISA DMA to PCI Memory Bridge

This block turns ISA DMA cycles into PCI memory transactions. There are seven DMA channels. Channels 0–3 carry bytes and channels 5–7 carry 16-bit words. Channel 4 has no request line and no acknowledge line. While the block is idle, a pending request makes it ask the PCI arbiter for the bus. After the grant, it drives the active-low acknowledge of the winning channel.

When the DMA controller pulls its memory read or memory write strobe low, the block holds the ISA cycle with the ready signal. It then runs one single-data-phase PCI memory transaction. The target address comes from a per-channel address input. Ready goes high again once the PCI handshake completes. For reads, the captured data stays on the ISA data bus until the strobe goes away.

The controller is a six-state machine:
- `ST_IDLE`: no bus request. *start* → `ST_ARB` when any request is active.
- `ST_ARB`: bus requested. *grant* → `ST_OWN`, latching the lowest pending channel. *abandon* → `ST_IDLE` when every request is gone.
- `ST_OWN`: acknowledge active, waiting for a strobe. *strobe* → `ST_ADDR`. *release* → `ST_IDLE` when the winner's request drops.
- `ST_ADDR`: PCI address phase. *advance* → `ST_DATA`.
- `ST_DATA`: PCI data phase. *handshake* → `ST_DONE` on an edge where TRDY# is low.
- `ST_DONE`: ISA cycle may finish. *retire* → `ST_OWN` once both strobes are high.

Top module: `isa_dma_pci_bridge`

## Requirements
- R1: Request and acknowledge pins map to channels as follows. Channels 0–3 use bit k of `dreq_lo_i` and `dack_lo_n_o`. Channels 5–7 use bit (ch−5) of `dreq_hi_i` and `dack_hi_n_o`. Each channel's address is `chan_addr_i[32*s +: 32]`, with slot s = ch for ch<4 and s = ch−1 otherwise.
- R2: A request seen while idle raises `bus_req_o` one cycle later. `bus_req_o` stays high until the winner's request is removed between transfers, and falls the cycle after that.
- R3: No acknowledge is active before the grant is sampled. The cycle after the grant is sampled, exactly one acknowledge is driven low.
- R4: The lowest-numbered pending channel wins at grant time. The acknowledge stays on that channel even when a lower-numbered request arrives later.
- R5: `iochrdy_o` goes low in the same cycle a strobe goes low while the channel is acknowledged. It stays low through the address and data phases.
- R6: The cycle after a strobe, FRAME# is low for exactly one cycle. During that cycle `ad_o` carries the channel address and `cbe_n_o` carries the command: 0110 for a read, 0111 for a write.
- R7: In the next cycle FRAME# is high and IRDY# is low. IRDY# stays low until TRDY# is sampled low. After that edge, IRDY# is high and `iochrdy_o` is high.
- R8: Data-phase byte enables are active low. A byte channel enables the single lane `addr[1:0]`. A word channel enables lanes 1:0 when `addr[1]`=0 and lanes 3:2 when `addr[1]`=1; `addr[0]` is ignored.
- R9: On a write, ISA data is latched when the strobe is accepted. A byte is taken from `isa_d_i[7:0]` when `addr[0]`=0 and from `isa_d_i[15:8]` when `addr[0]`=1, then copied to all four AD lanes. A word is copied to both AD halves. `ad_oe_o` is high in the write data phase, and the ISA data bus is never driven during a write.
- R10: On a read, AD is captured at the handshake edge and driven on `isa_d_o` with `isa_d_oe_o` high until the strobe is removed. A word takes the half selected by `addr[1]`. A byte is taken from lane `addr[1:0]`, placed on the ISA lane selected by `addr[0]`, and the other lane is zero.
- R11: After reset, the bus request, acknowledges, FRAME#, IRDY#, AD enable and ISA data enable are all inactive, `cbe_n_o` is 1111 and `iochrdy_o` is high.
- R12: Once the strobe is removed, the block returns to acknowledged-idle with all PCI and ISA data drivers off, ready for the next transfer on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dreq_lo_i | input | 4 | DMA requests, channels 0–3 |
| dreq_hi_i | input | 3 | DMA requests, channels 5–7 |
| dack_lo_n_o | output | 4 | Active-low acknowledges, channels 0–3 |
| dack_hi_n_o | output | 3 | Active-low acknowledges, channels 5–7 |
| chan_addr_i | input | 224 | Per-channel PCI byte address, 32 bits per slot |
| bus_req_o | output | 1 | Bus request to the PCI arbiter |
| bus_gnt_i | input | 1 | Bus grant from the PCI arbiter |
| memr_n_i | input | 1 | ISA memory read strobe, active low |
| memw_n_i | input | 1 | ISA memory write strobe, active low |
| isa_d_i | input | 16 | ISA data in (write transfers) |
| isa_d_o | output | 16 | ISA data out (read transfers) |
| isa_d_oe_o | output | 1 | ISA data output enable |
| iochrdy_o | output | 1 | ISA ready, low holds the cycle |
| frame_n_o | output | 1 | PCI FRAME# |
| irdy_n_o | output | 1 | PCI IRDY# |
| trdy_n_i | input | 1 | PCI TRDY# |
| cbe_n_o | output | 4 | PCI command / byte enables |
| ad_o | output | 32 | PCI AD out |
| ad_oe_o | output | 1 | PCI AD output enable |
| ad_i | input | 32 | PCI AD in |

## Verification
Each result has its own timing:
- `bus_req_o` rises one edge after the request.
- An acknowledge appears one edge after the grant.
- Ready falls in the same cycle as the strobe.
- The address phase comes one edge after the strobe, and the data phase one edge after that.
- Ready rises, and read data appears, on the first edge after TRDY# is driven low.

The bench drives every input on a falling edge. It counts rising edges from that point according to the list above and samples on the falling edge that follows. The combinational ready check is the exception: it is sampled one nanosecond after the strobe changes.

Target wait states of zero and of several cycles are both covered. In the wait-state cases, ready and IRDY# are checked on every waiting cycle.

// File: rtl/dmabr_pkg.sv
package dmabr_pkg;
    localparam int PCI_DW = 32;
    localparam int ISA_DW = 16;
    localparam int CBE_W  = PCI_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_OWN,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } dma_state_e;

    localparam logic [CBE_W-1:0] CMD_MEM_RD = 4'b0110;
    localparam logic [CBE_W-1:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/dmabr_pick.sv
module dmabr_pick #(
    parameter int NCH = 7
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick,
    output logic           any
);
    assign any = |req;

    for (genvar i = 0; i < NCH; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign pick[i] = req[i];
        end else begin : g_rest
            assign pick[i] = req[i] & ~(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/dmabr_lane.sv
module dmabr_lane
    import dmabr_pkg::*;
(
    input  logic              is_word,
    input  logic [1:0]        lo,
    input  logic [ISA_DW-1:0] isa_wr,
    input  logic [PCI_DW-1:0] pci_rd,
    output logic [CBE_W-1:0]  be_n,
    output logic [PCI_DW-1:0] pci_wr,
    output logic [ISA_DW-1:0] isa_rd
);
    logic [7:0]  byte_wr;
    logic [7:0]  byte_rd;
    logic [15:0] half_rd;

    always_comb begin
        byte_wr = lo[0] ? isa_wr[15:8] : isa_wr[7:0];
        byte_rd = pci_rd[8*lo +: 8];
        half_rd = lo[1] ? pci_rd[31:16] : pci_rd[15:0];
        if (is_word) begin
            be_n   = lo[1] ? 4'b0011 : 4'b1100;
            pci_wr = {2{isa_wr}};
            isa_rd = half_rd;
        end else begin
            be_n   = ~(4'b0001 << lo);
            pci_wr = {4{byte_wr}};
            isa_rd = lo[0] ? {byte_rd, 8'h00} : {8'h00, byte_rd};
        end
    end
endmodule

// File: rtl/isa_dma_pci_bridge.sv
module isa_dma_pci_bridge
    import dmabr_pkg::*;
#(
    parameter int NLO = 4,
    parameter int NHI = 3,
    parameter int AW  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLO-1:0]        dreq_lo_i,
    input  logic [NHI-1:0]        dreq_hi_i,
    output logic [NLO-1:0]        dack_lo_n_o,
    output logic [NHI-1:0]        dack_hi_n_o,
    input  logic [(NLO+NHI)*AW-1:0] chan_addr_i,
    output logic                  bus_req_o,
    input  logic                  bus_gnt_i,
    input  logic                  memr_n_i,
    input  logic                  memw_n_i,
    input  logic [ISA_DW-1:0]     isa_d_i,
    output logic [ISA_DW-1:0]     isa_d_o,
    output logic                  isa_d_oe_o,
    output logic                  iochrdy_o,
    output logic                  frame_n_o,
    output logic                  irdy_n_o,
    input  logic                  trdy_n_i,
    output logic [CBE_W-1:0]      cbe_n_o,
    output logic [AW-1:0]         ad_o,
    output logic                  ad_oe_o,
    input  logic [PCI_DW-1:0]     ad_i
);
    localparam int NCH = NLO + NHI;

    dma_state_e        state, nxt;
    logic [NCH-1:0]    req, pick, win_q, ack;
    logic              any_req, strobe, win_held, word_q, wr_q;
    logic [AW-1:0]     addr_q, addr_sel;
    logic [ISA_DW-1:0] wdat_q;
    logic [PCI_DW-1:0] rdat_q;
    logic [CBE_W-1:0]  be_n;
    logic [PCI_DW-1:0] pci_wr;
    logic [ISA_DW-1:0] isa_rd;

    assign req      = {dreq_hi_i, dreq_lo_i};
    assign strobe   = !memr_n_i || !memw_n_i;
    assign win_held = |(req & win_q);

    dmabr_pick #(.NCH(NCH)) i_pick (
        .req  (req),
        .pick (pick),
        .any  (any_req)
    );

    dmabr_lane i_lane (
        .is_word (word_q),
        .lo      (addr_q[1:0]),
        .isa_wr  (wdat_q),
        .pci_rd  (rdat_q),
        .be_n    (be_n),
        .pci_wr  (pci_wr),
        .isa_rd  (isa_rd)
    );

    always_comb begin
        addr_sel = '0;
        for (int s = 0; s < NCH; s++) begin
            if (win_q[s]) addr_sel = addr_sel | chan_addr_i[s*AW +: AW];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (any_req) nxt = ST_ARB;
            ST_ARB: begin
                if (!any_req)      nxt = ST_IDLE;
                else if (bus_gnt_i) nxt = ST_OWN;
            end
            ST_OWN: begin
                if (strobe)         nxt = ST_ADDR;
                else if (!win_held) nxt = ST_IDLE;
            end
            ST_ADDR: nxt = ST_DATA;
            ST_DATA: if (!trdy_n_i) nxt = ST_DONE;
            ST_DONE: if (!strobe)   nxt = ST_OWN;
            default: nxt = ST_IDLE;
        endcase
    end

    // transfer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            word_q <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (state == ST_ARB && any_req && bus_gnt_i) begin
                win_q  <= pick;
                word_q <= |pick[NCH-1:NLO];
            end
            if (state == ST_OWN && strobe) begin
                wr_q   <= memr_n_i;
                addr_q <= addr_sel;
                wdat_q <= isa_d_i;
            end
            if (state == ST_DATA && !trdy_n_i) rdat_q <= ad_i;
        end
    end

    // outputs
    always_comb begin
        ack         = (state == ST_OWN || state == ST_ADDR ||
                       state == ST_DATA || state == ST_DONE) ? win_q : '0;
        dack_lo_n_o = ~ack[NLO-1:0];
        dack_hi_n_o = ~ack[NCH-1:NLO];
        bus_req_o   = (state != ST_IDLE);
        iochrdy_o   = !((state == ST_OWN && strobe) ||
                        state == ST_ADDR || state == ST_DATA);
        frame_n_o   = (state != ST_ADDR);
        irdy_n_o    = (state != ST_DATA);
        ad_oe_o     = (state == ST_ADDR) || (state == ST_DATA && wr_q);
        ad_o        = '0;
        cbe_n_o     = '1;
        if (state == ST_ADDR) begin
            ad_o    = addr_q;
            cbe_n_o = wr_q ? CMD_MEM_WR : CMD_MEM_RD;
        end else if (state == ST_DATA) begin
            ad_o    = wr_q ? pci_wr : '0;
            cbe_n_o = be_n;
        end
        isa_d_oe_o  = (state == ST_DONE) && !wr_q;
        isa_d_o     = isa_d_oe_o ? isa_rd : '0;
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{dack_hi_n_o, dack_lo_n_o})); // R3
    AST_ACK_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|(~{dack_hi_n_o, dack_lo_n_o})) |-> $past(bus_gnt_i)); // R3
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~{dack_hi_n_o, dack_lo_n_o})) |-> bus_req_o); // R2
    AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(~{dack_hi_n_o, dack_lo_n_o})) && $past(|(~{dack_hi_n_o, dack_lo_n_o})))
        |-> $stable({dack_hi_n_o, dack_lo_n_o})); // R4
    AST_FRAME_HOLDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |-> !iochrdy_o); // R5
    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |-> (cbe_n_o == CMD_MEM_RD || cbe_n_o == CMD_MEM_WR)); // R6
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |=> (frame_n_o && !irdy_n_o)); // R7
    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n_o && !trdy_n_i) |=> (iochrdy_o && irdy_n_o)); // R7
    AST_BE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !irdy_n_o |-> ($countones(~cbe_n_o) == 1 || $countones(~cbe_n_o) == 2)); // R8
endmodule

// File: tb/test_isa_dma_pci_bridge.sv
module test_isa_dma_pci_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dreq_lo = '0;
    logic [2:0]  dreq_hi = '0;
    logic [3:0]  dack_lo_n;
    logic [2:0]  dack_hi_n;
    logic [223:0] chan_addr = '0;
    logic        bus_req, bus_gnt = 1'b0;
    logic        memr_n = 1'b1, memw_n = 1'b1;
    logic [15:0] isa_d_in = '0, isa_d_out;
    logic        isa_oe, iochrdy, frame_n, irdy_n;
    logic        trdy_n = 1'b1;
    logic [3:0]  cbe_n;
    logic [31:0] ad_out, ad_in = '0;
    logic        ad_oe;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    isa_dma_pci_bridge i_isa_dma_pci_bridge (
        .clk(clk), .rst_n(rst_n),
        .dreq_lo_i(dreq_lo), .dreq_hi_i(dreq_hi),
        .dack_lo_n_o(dack_lo_n), .dack_hi_n_o(dack_hi_n),
        .chan_addr_i(chan_addr),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
        .memr_n_i(memr_n), .memw_n_i(memw_n),
        .isa_d_i(isa_d_in), .isa_d_o(isa_d_out), .isa_d_oe_o(isa_oe),
        .iochrdy_o(iochrdy), .frame_n_o(frame_n), .irdy_n_o(irdy_n),
        .trdy_n_i(trdy_n), .cbe_n_o(cbe_n), .ad_o(ad_out), .ad_oe_o(ad_oe),
        .ad_i(ad_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_addr(input int ch, input logic [31:0] a);
        int slot = (ch < 4) ? ch : ch - 1;
        chan_addr[slot*32 +: 32] = a;
    endtask

    task automatic t_reset();
        chk("R11 bus_req", {31'b0, bus_req}, 0);
        chk("R11 dack", {25'b0, dack_hi_n, dack_lo_n}, 32'h7f);
        chk("R11 frame/irdy", {30'b0, frame_n, irdy_n}, 3);
        chk("R11 iochrdy", {31'b0, iochrdy}, 1);
        chk("R11 oe", {30'b0, ad_oe, isa_oe}, 0);
        chk("R11 cbe", {28'b0, cbe_n}, 4'hf);
    endtask

    task automatic t_grant();
        dreq_lo[2] = 1'b1;
        step();
        chk("R2 bus_req rise", {31'b0, bus_req}, 1);
        chk("R3 no ack before grant", {25'b0, dack_hi_n, dack_lo_n}, 32'h7f);
        step();
        chk("R3 still no ack", {25'b0, dack_hi_n, dack_lo_n}, 32'h7f);
        bus_gnt = 1'b1;
        step();
        chk("R1 R3 ack ch2", {25'b0, dack_hi_n, dack_lo_n}, {25'b0, 3'b111, 4'b1011});
    endtask

    task automatic xfer(input bit rd, input logic [31:0] addr, input logic [15:0] wd,
                        input logic [31:0] rdata, input int waits,
                        input logic [3:0] exp_be_n, input logic [31:0] exp_val);
        isa_d_in = wd;
        if (rd) memr_n = 1'b0; else memw_n = 1'b0;
        #1;
        chk("R5 ready low on strobe", {31'b0, iochrdy}, 0);
        step();
        chk("R6 frame low", {31'b0, frame_n}, 0);
        chk("R6 address", ad_out, addr);
        chk("R6 command", {28'b0, cbe_n}, rd ? 32'h6 : 32'h7);
        chk("R5 ready low in addr", {31'b0, iochrdy}, 0);
        step();
        chk("R7 frame high irdy low", {30'b0, frame_n, irdy_n}, 2);
        chk("R8 byte enables", {28'b0, cbe_n}, {28'b0, exp_be_n});
        if (!rd) begin
            chk("R9 write data", ad_out, exp_val);
            chk("R9 ad_oe", {31'b0, ad_oe}, 1);
        end
        for (int w = 0; w < waits; w++) begin
            step();
            chk("R7 wait ready low", {31'b0, iochrdy}, 0);
            chk("R7 wait irdy low", {31'b0, irdy_n}, 0);
        end
        ad_in  = rdata;
        trdy_n = 1'b0;
        step();
        trdy_n = 1'b1;
        ad_in  = 32'hdead_beef;
        chk("R7 ready high after handshake", {31'b0, iochrdy}, 1);
        chk("R7 irdy released", {31'b0, irdy_n}, 1);
        if (rd) begin
            chk("R10 isa oe", {31'b0, isa_oe}, 1);
            chk("R10 read data", {16'b0, isa_d_out}, {16'b0, exp_val[15:0]});
            step();
            chk("R10 read data held", {16'b0, isa_d_out}, {16'b0, exp_val[15:0]});
        end else begin
            chk("R9 isa not driven on write", {31'b0, isa_oe}, 0);
            step();
        end
        memr_n = 1'b1;
        memw_n = 1'b1;
        step();
        chk("R12 drivers off", {30'b0, isa_oe, ad_oe}, 0);
        chk("R12 pci idle", {30'b0, frame_n, irdy_n}, 3);
    endtask

    task automatic t_write_byte();
        set_addr(2, 32'h0000_3001);
        xfer(1'b0, 32'h0000_3001, 16'h5a00, 32'h0, 0, 4'b1101, 32'h5a5a_5a5a);
        chk("R12 ack kept", {28'b0, dack_lo_n}, 4'b1011);
        dreq_lo[2] = 1'b0;
        step();
        chk("R2 bus_req drop", {31'b0, bus_req}, 0);
        chk("R2 ack drop", {25'b0, dack_hi_n, dack_lo_n}, 32'h7f);
    endtask

    task automatic t_priority();
        dreq_lo[1] = 1'b1;
        dreq_hi[1] = 1'b1;
        step();
        step();
        chk("R4 lowest wins", {25'b0, dack_hi_n, dack_lo_n}, {25'b0, 3'b111, 4'b1101});
        dreq_lo[0] = 1'b1;
        step();
        step();
        chk("R4 no preemption", {25'b0, dack_hi_n, dack_lo_n}, {25'b0, 3'b111, 4'b1101});
        set_addr(1, 32'h0000_1003);
        xfer(1'b1, 32'h0000_1003, 16'h0, 32'ha1b2_c3d4, 2, 4'b0111, 32'h0000_a100);
        dreq_lo[1] = 1'b0;
        step();
        chk("R2 release between transfers", {31'b0, bus_req}, 0);
        step();
        step();
        chk("R4 next lowest ch0", {25'b0, dack_hi_n, dack_lo_n}, {25'b0, 3'b111, 4'b1110});
        dreq_lo[0] = 1'b0;
        step();
        step();
        step();
        chk("R1 R4 ack ch6", {25'b0, dack_hi_n, dack_lo_n}, {25'b0, 3'b101, 4'b1111});
    endtask

    task automatic t_words();
        set_addr(6, 32'h0000_2002);
        xfer(1'b0, 32'h0000_2002, 16'hbeef, 32'h0, 1, 4'b0011, 32'hbeef_beef);
        set_addr(6, 32'h0000_0004);
        xfer(1'b1, 32'h0000_0004, 16'h0, 32'h1234_5678, 0, 4'b1100, 32'h0000_5678);
        set_addr(6, 32'h0000_0007);
        xfer(1'b1, 32'h0000_0007, 16'h0, 32'h1234_5678, 3, 4'b0011, 32'h0000_1234);
        dreq_hi[1] = 1'b0;
        step();
        chk("R2 final release", {31'b0, bus_req}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_grant();
        t_write_byte();
        t_priority();
        t_words();
        repeat (2) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule